// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Bank Tracker

This block is the command front end of a behavioural DDR SDRAM device model. On every rising clock edge it samples the chip select, the three command strobes, the clock enable, the bank address and the address bus. It turns these into one decoded command. It also keeps, for each of four banks, whether a row is open and which row it is. The memory array and the data path use its outputs to decide which bank, row and column a burst touches.

Accesses are checked against the bank state. A read or write to an idle bank is refused, and so is an activate to a bank that already has an open row. Each refusal sets a protocol-error flag that stays set until reset. Address bit 10 has a role that depends on the command:
- On a read or write it requests a self-timed precharge once the burst ends.
- On a precharge it selects either the addressed bank alone or every bank.

When the clock enable drops, the block records which low-power state the device enters. While the clock enable is low, commands are not forwarded.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: Outputs are registered: a command sampled at one rising edge appears on the outputs after that same edge. `cmd_o` carries the sampled {RAS,CAS,WE} code, all active low: 011 Active, 101 Read, 100 Write, 010 Precharge, 001 Refresh, 000 Mode Register Set. `cmd_valid_o` is 1 only for a forwarded command. Codes 111 (no operation) and 110 are never forwarded.
- R2: When `cs_ni` is sampled high, the command is ignored: no command is forwarded, and no bank, error or power state changes.
- R3: An accepted Active opens the bank given by `ba_i` and stores `addr_i[12:0]` as its row. That row appears on `row_o` and in that bank's 13-bit slice of `open_row_o`; bank i's slice is bits [13i+12:13i]. An open bank's row does not change until the bank closes.
- R4: On an accepted Read or Write, `col_o` is {`addr_i[11]`, `addr_i[9:0]`} and `ap_o` is `addr_i[10]`.
- R5: A Precharge with `addr_i[10]`=0 closes only bank `ba_i`. A Precharge with `addr_i[10]`=1 closes all banks. A Precharge is forwarded whatever the bank state, with `ap_o` showing bit 10.
- R6: A Read or Write to an idle bank, or an Active to an open bank, is not forwarded and leaves all bank state unchanged. It sets `proto_err_o`, which stays 1 until reset.
- R7: An accepted Read or Write with `addr_i[10]`=1 closes its bank exactly AP_DELAY rising edges after the edge that sampled it, unless a Precharge closes the bank earlier. A later Read or Write with bit 10 set restarts the count.
- R8: The power state `pwr_o` is 0 for running, 1 for precharge power-down, 2 for active power-down and 3 for self refresh. It changes on the edge that first samples `cke_i` low:
  - to 3 if that edge also samples a Refresh code with `cs_ni` low;
  - otherwise to 2 if any bank is open;
  - otherwise to 1.
  It returns to 0 on the first edge that samples `cke_i` high. No command is forwarded on an edge where `cke_i` is low or where `pwr_o` is not 0.
- R9: An accepted Mode Register Set is forwarded with `bank_o` equal to `ba_i`, which selects the mode or extended mode register, and `row_o` equal to the full address op-code. It does not change any bank state.
- R10: After reset, `cmd_valid_o`, `bank_open_o`, `proto_err_o` and `pwr_o` are 0, and `cmd_o` is 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank address |
| addr_i | input | 13 | Row, column, bit-10 flag or op-code |
| cmd_valid_o | output | 1 | Forwarded command strobe |
| cmd_o | output | 3 | Command code {RAS,CAS,WE} |
| bank_o | output | 2 | Target bank or mode register select |
| row_o | output | 13 | Row address or op-code |
| col_o | output | 11 | Column address |
| ap_o | output | 1 | Address bit 10 (auto precharge or all banks) |
| bank_open_o | output | 4 | Per-bank open flag |
| open_row_o | output | 52 | Open row per bank, 13 bits each |
| proto_err_o | output | 1 | Sticky protocol-error flag |
| pwr_o | output | 2 | Power state |

## Verification
The bench builds the block with four banks, 13-bit rows, 11-bit columns and AP_DELAY set to 3. The short auto-precharge window makes it cheap to watch every closing edge, and to watch a bank that is hit again before its count runs out. With only four banks, the bench can sweep every strobe code with chip select high and low across every bank. It also covers every bank under both precharge forms and every low-power entry path, comparing all outputs after each edge.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;
  typedef enum logic [2:0] {
    CMD_MRS = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_BST = 3'b110,
    CMD_NOP = 3'b111
  } cmd_e;

  typedef enum logic [1:0] {
    PWR_RUN      = 2'd0,
    PWR_PRE_PD   = 2'd1,
    PWR_ACT_PD   = 2'd2,
    PWR_SELF_REF = 2'd3
  } pwr_e;
endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_cmd_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int COL_W  = 11,
  parameter int AP_BIT = 10
) (
  input  logic              cs_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output cmd_e              cmd_o,
  output logic              is_act_o,
  output logic              is_rw_o,
  output logic              is_pre_o,
  output logic              is_ref_o,
  output logic              is_mrs_o,
  output logic [COL_W-1:0]  col_o,
  output logic              ap_o
);
  localparam int HI_W = COL_W - AP_BIT;

  always_comb begin
    cmd_o = cs_ni ? CMD_NOP : cmd_e'({ras_ni, cas_ni, we_ni});
  end

  assign is_act_o = (cmd_o == CMD_ACT);
  assign is_rw_o  = (cmd_o == CMD_RD) || (cmd_o == CMD_WR);
  assign is_pre_o = (cmd_o == CMD_PRE);
  assign is_ref_o = (cmd_o == CMD_REF);
  assign is_mrs_o = (cmd_o == CMD_MRS);
  // column skips the flag bit
  assign col_o    = {addr_i[AP_BIT+1 +: HI_W], addr_i[AP_BIT-1:0]};
  assign ap_o     = addr_i[AP_BIT];

  always_comb begin
    AST_ONE_CLASS: assert ($countones({is_act_o, is_rw_o, is_pre_o, is_ref_o, is_mrs_o}) <= 1); // R1
  end
endmodule

// File: rtl/ddr_bank_slot.sv
module ddr_bank_slot #(
  parameter int ROW_W    = 13,
  parameter int AP_DELAY = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic             rw_ap_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int CNT_W = (AP_DELAY < 2) ? 1 : $clog2(AP_DELAY);

  logic             pend_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_o <= 1'b0;
      row_o  <= '0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (act_i) begin
      open_o <= 1'b1;
      row_o  <= row_i;
      pend_q <= 1'b0;
    end else if (pre_i) begin
      open_o <= 1'b0;
      pend_q <= 1'b0;
    end else if (rw_ap_i) begin
      pend_q <= 1'b1;
      cnt_q  <= CNT_W'(AP_DELAY - 1);
    end else if (pend_q) begin
      if (cnt_q == '0) begin
        open_o <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  AST_AP_ON_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> open_o); // R7
  AST_ROW_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_o && !act_i) |=> $stable(row_o)); // R3
  AST_ACT_IDLE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |-> !open_o); // R6
endmodule

// File: rtl/ddr_pwr_track.sv
module ddr_pwr_track
  import ddr_cmd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cke_i,
  input  logic ref_req_i,
  input  logic any_open_i,
  output logic run_o,
  output pwr_e pwr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_o <= PWR_RUN;
    end else if (pwr_o == PWR_RUN) begin
      if (!cke_i) begin
        if (ref_req_i)       pwr_o <= PWR_SELF_REF;
        else if (any_open_i) pwr_o <= PWR_ACT_PD;
        else                 pwr_o <= PWR_PRE_PD;
      end
    end else if (cke_i) begin
      pwr_o <= PWR_RUN;
    end
  end

  // exit edge itself is not a command edge
  assign run_o = cke_i && (pwr_o == PWR_RUN);

  AST_EXIT_ON_CKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_o != PWR_RUN && cke_i) |=> pwr_o == PWR_RUN); // R8
  AST_STAY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_o != PWR_RUN && !cke_i) |=> $stable(pwr_o)); // R8
endmodule

// File: rtl/ddr_cmd_tracker.sv
module ddr_cmd_tracker
  import ddr_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int ADDR_W    = 13,
  parameter int COL_W     = 11,
  parameter int AP_BIT    = 10,
  parameter int AP_DELAY  = 4,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cke_i,
  input  logic                       cs_ni,
  input  logic                       ras_ni,
  input  logic                       cas_ni,
  input  logic                       we_ni,
  input  logic [BA_W-1:0]            ba_i,
  input  logic [ADDR_W-1:0]          addr_i,
  output logic                       cmd_valid_o,
  output logic [2:0]                 cmd_o,
  output logic [BA_W-1:0]            bank_o,
  output logic [ROW_W-1:0]           row_o,
  output logic [COL_W-1:0]           col_o,
  output logic                       ap_o,
  output logic [NUM_BANKS-1:0]       bank_open_o,
  output logic [NUM_BANKS*ROW_W-1:0] open_row_o,
  output logic                       proto_err_o,
  output logic [1:0]                 pwr_o
);
  cmd_e             dec_cmd;
  logic             is_act, is_rw, is_pre, is_ref, is_mrs, dec_ap;
  logic [COL_W-1:0] dec_col;
  logic             run;
  pwr_e             pwr_state;
  logic [NUM_BANKS-1:0] bank_sel;
  logic             tgt_open;
  logic             act_ok, act_err, rw_ok, rw_err, pre_go, fwd;

  ddr_cmd_decode #(
    .ADDR_W (ADDR_W),
    .COL_W  (COL_W),
    .AP_BIT (AP_BIT)
  ) u_decode (
    .cs_ni    (cs_ni),
    .ras_ni   (ras_ni),
    .cas_ni   (cas_ni),
    .we_ni    (we_ni),
    .addr_i   (addr_i),
    .cmd_o    (dec_cmd),
    .is_act_o (is_act),
    .is_rw_o  (is_rw),
    .is_pre_o (is_pre),
    .is_ref_o (is_ref),
    .is_mrs_o (is_mrs),
    .col_o    (dec_col),
    .ap_o     (dec_ap)
  );

  ddr_pwr_track u_pwr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cke_i      (cke_i),
    .ref_req_i  (is_ref),
    .any_open_i (|bank_open_o),
    .run_o      (run),
    .pwr_o      (pwr_state)
  );

  assign bank_sel = NUM_BANKS'(1) << ba_i;
  assign tgt_open = bank_open_o[ba_i];
  assign act_ok   = run && is_act && !tgt_open;
  assign act_err  = run && is_act && tgt_open;
  assign rw_ok    = run && is_rw && tgt_open;
  assign rw_err   = run && is_rw && !tgt_open;
  assign pre_go   = run && is_pre;
  assign fwd      = act_ok || rw_ok || pre_go || (run && (is_ref || is_mrs));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    ddr_bank_slot #(
      .ROW_W    (ROW_W),
      .AP_DELAY (AP_DELAY)
    ) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .act_i   (act_ok && bank_sel[b]),
      .pre_i   (pre_go && (dec_ap || bank_sel[b])),
      .rw_ap_i (rw_ok && dec_ap && bank_sel[b]),
      .row_i   (addr_i[ROW_W-1:0]),
      .open_o  (bank_open_o[b]),
      .row_o   (open_row_o[b*ROW_W +: ROW_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_valid_o <= 1'b0;
      cmd_o       <= CMD_NOP;
      bank_o      <= '0;
      row_o       <= '0;
      col_o       <= '0;
      ap_o        <= 1'b0;
      proto_err_o <= 1'b0;
    end else begin
      cmd_valid_o <= fwd;
      cmd_o       <= dec_cmd;
      bank_o      <= ba_i;
      row_o       <= addr_i[ROW_W-1:0];
      col_o       <= dec_col;
      ap_o        <= dec_ap;
      proto_err_o <= proto_err_o || act_err || rw_err;
    end
  end

  assign pwr_o = pwr_state;

  AST_CS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !cmd_valid_o); // R2
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |=> proto_err_o); // R6
  AST_ACT_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_o == CMD_ACT) |->
      (bank_open_o[bank_o] && open_row_o[bank_o*ROW_W +: ROW_W] == row_o)); // R3
  AST_RW_NEEDS_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && (cmd_o == CMD_RD || cmd_o == CMD_WR)) |-> $past(bank_open_o[ba_i])); // R6
  AST_PRE_ALL_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_o == CMD_PRE && ap_o) |-> bank_open_o == '0); // R5
  AST_LOWPWR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_o != PWR_RUN) |-> !cmd_valid_o); // R8
  AST_NOP_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_NOP || cmd_o == CMD_BST) |-> !cmd_valid_o); // R1
endmodule

// File: tb/ddr_cmd_tracker_tb.sv
`timescale 1ns/1ps
module ddr_cmd_tracker_tb;
  localparam int AD = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;
  logic        v_o, ap_o, err_o;
  logic [2:0]  cmd_o;
  logic [1:0]  bank_o, pwr_o;
  logic [12:0] row_o;
  logic [10:0] col_o;
  logic [3:0]  open_o;
  logic [51:0] orow_o;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  bit         m_open[4];
  logic [12:0] m_row[4];
  bit         m_pend[4];
  int         m_cnt[4];
  bit         m_err;
  int         m_pwr;

  always #4 clk = ~clk;

  ddr_cmd_tracker #(.AP_DELAY(AD)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n),
    .cas_ni(cas_n), .we_ni(we_n), .ba_i(ba), .addr_i(addr),
    .cmd_valid_o(v_o), .cmd_o(cmd_o), .bank_o(bank_o), .row_o(row_o),
    .col_o(col_o), .ap_o(ap_o), .bank_open_o(open_o), .open_row_o(orow_o),
    .proto_err_o(err_o), .pwr_o(pwr_o));

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 4; i++) begin
      m_open[i] = 0; m_row[i] = '0; m_pend[i] = 0; m_cnt[i] = 0;
    end
    m_err = 0; m_pwr = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cke = 1'b1; cs_n = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_clear();
    @(negedge clk);
  endtask

  task automatic compare_state(input string tag);
    for (int i = 0; i < 4; i++) begin
      chk(open_o[i] == m_open[i], tag, $sformatf("bank%0d open", i), 64'(open_o[i]), 64'(m_open[i]));
      if (m_open[i])
        chk(orow_o[i*13 +: 13] == m_row[i], tag, $sformatf("bank%0d row", i),
            64'(orow_o[i*13 +: 13]), 64'(m_row[i]));
    end
    chk(err_o == m_err, tag, "proto_err", 64'(err_o), 64'(m_err));
    chk(pwr_o == 2'(m_pwr), tag, "pwr", 64'(pwr_o), 64'(m_pwr));
  endtask

  // one command edge: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input string tag, input bit k, input bit c,
                      input logic [2:0] code, input logic [1:0] b, input logic [12:0] a);
    bit en, csl, ev, anyo, all;
    bit touch[4];
    cke = k; cs_n = c; {ras_n, cas_n, we_n} = code; ba = b; addr = a;
    @(posedge clk);
    en = k && (m_pwr == 0);
    csl = !c;
    ev = 0; all = a[10];
    anyo = m_open[0] || m_open[1] || m_open[2] || m_open[3];
    for (int i = 0; i < 4; i++) touch[i] = 0;
    if (en && csl) begin
      case (code)
        3'b011: if (m_open[b]) m_err = 1;
                else begin ev = 1; m_open[b] = 1; m_row[b] = a; m_pend[b] = 0; touch[b] = 1; end
        3'b101, 3'b100:
                if (!m_open[b]) m_err = 1;
                else begin
                  ev = 1;
                  if (a[10]) begin m_pend[b] = 1; m_cnt[b] = AD - 1; touch[b] = 1; end
                end
        3'b010: begin
                  ev = 1;
                  for (int i = 0; i < 4; i++)
                    if (all || i == int'(b)) begin m_open[i] = 0; m_pend[i] = 0; touch[i] = 1; end
                end
        3'b001, 3'b000: ev = 1;
        default: ev = 0;
      endcase
    end
    for (int i = 0; i < 4; i++)
      if (!touch[i] && m_pend[i]) begin
        if (m_cnt[i] == 0) begin m_open[i] = 0; m_pend[i] = 0; end
        else m_cnt[i]--;
      end
    if (m_pwr == 0 && !k) m_pwr = (csl && code == 3'b001) ? 3 : (anyo ? 2 : 1);
    else if (m_pwr != 0 && k) m_pwr = 0;
    @(negedge clk);
    chk(v_o == ev, tag, "cmd_valid", 64'(v_o), 64'(ev));
    if (ev) begin
      chk(cmd_o == code, tag, "cmd", 64'(cmd_o), 64'(code));
      chk(bank_o == b, tag, "bank", 64'(bank_o), 64'(b));
      if (code == 3'b011 || code == 3'b000)
        chk(row_o == a, tag, "row/opcode", 64'(row_o), 64'(a));
      if (code == 3'b101 || code == 3'b100)
        chk(col_o == {a[11], a[9:0]}, tag, "col", 64'(col_o), 64'({a[11], a[9:0]}));
      if (code != 3'b011 && code != 3'b001 && code != 3'b000)
        chk(ap_o == a[10], tag, "ap", 64'(ap_o), 64'(a[10]));
    end
    compare_state(tag);
  endtask

  task automatic nop(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 1'b1, 1'b0, 3'b111, 2'd0, 13'h0);
  endtask

  initial begin
    logic [12:0] pats[4];
    pats[0] = 13'h0000; pats[1] = 13'h0BFF; pats[2] = 13'h0855; pats[3] = 13'h13AA;
    model_clear();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(v_o == 1'b0, "R10", "cmd_valid", 64'(v_o), 64'h0);
    chk(cmd_o == 3'b111, "R10", "cmd", 64'(cmd_o), 64'h7);
    compare_state("R10");

    // R3 open every bank with distinct rows
    for (int b = 0; b < 4; b++)
      step("R3", 1, 0, 3'b011, 2'(b), 13'(b * 13'h0923 + 13'h00A5));
    // R4 column mapping, bit 10 clear
    for (int b = 0; b < 4; b++)
      for (int p = 0; p < 4; p++) begin
        step("R4", 1, 0, 3'b101, 2'(b), pats[p] & 13'h1BFF);
        step("R4", 1, 0, 3'b100, 2'(b), pats[p] & 13'h1BFF);
      end
    // R2 every code with chip select high, every bank
    for (int b = 0; b < 4; b++)
      for (int c = 0; c < 8; c++)
        step("R2", 1, 1, 3'(c), 2'(b), 13'h1400);
    // R9 mode register set, R1 refresh
    for (int b = 0; b < 4; b++) begin
      step("R9", 1, 0, 3'b000, 2'(b), 13'(13'h0123 << b));
      step("R1", 1, 0, 3'b001, 2'(b), 13'h0);
    end
    // R1 no-operation and 110 not forwarded
    step("R1", 1, 0, 3'b111, 2'd1, 13'h0);
    step("R1", 1, 0, 3'b110, 2'd2, 13'h0);
    // R5 single-bank precharge on each bank, reopen, then all
    for (int b = 0; b < 4; b++) begin
      step("R5", 1, 0, 3'b010, 2'(b), 13'h0000);
      step("R5", 1, 0, 3'b011, 2'(b), 13'h1F0F);
    end
    step("R5", 1, 0, 3'b010, 2'd1, 13'h0400);
    step("R5", 1, 0, 3'b010, 2'd3, 13'h0400);

    // R6 read and write to idle bank, double activate
    step("R6", 1, 0, 3'b101, 2'd0, 13'h0012);
    step("R6", 1, 0, 3'b100, 2'd2, 13'h0012);
    step("R6", 1, 0, 3'b011, 2'd3, 13'h0AAA);
    step("R6", 1, 0, 3'b011, 2'd3, 13'h1555);
    nop("R6", 2);
    do_reset();
    compare_state("R10");

    // R7 auto precharge timing on each bank
    for (int b = 0; b < 4; b++) begin
      step("R7", 1, 0, 3'b011, 2'(b), 13'h0042);
      step("R7", 1, 0, (b % 2) ? 3'b100 : 3'b101, 2'(b), 13'h0401);
      nop("R7", AD + 1);
    end
    // R7 restart and read without flag during window
    step("R7", 1, 0, 3'b011, 2'd1, 13'h0033);
    step("R7", 1, 0, 3'b101, 2'd1, 13'h0400);
    nop("R7", 1);
    step("R7", 1, 0, 3'b100, 2'd1, 13'h0400);
    step("R7", 1, 0, 3'b101, 2'd1, 13'h0000);
    nop("R7", AD);
    // R7 precharge cuts window short
    step("R7", 1, 0, 3'b011, 2'd2, 13'h0077);
    step("R7", 1, 0, 3'b100, 2'd2, 13'h0400);
    step("R7", 1, 0, 3'b010, 2'd2, 13'h0000);
    nop("R7", AD);

    // R8 precharge power-down, ignored commands, exit
    step("R8", 0, 0, 3'b111, 2'd0, 13'h0);
    step("R8", 0, 0, 3'b011, 2'd0, 13'h0011);
    step("R8", 1, 0, 3'b011, 2'd0, 13'h0011);
    step("R8", 1, 0, 3'b011, 2'd0, 13'h0022);
    // active power-down
    step("R8", 0, 0, 3'b111, 2'd0, 13'h0);
    step("R8", 0, 0, 3'b010, 2'd0, 13'h0400);
    step("R8", 1, 0, 3'b111, 2'd0, 13'h0);
    step("R8", 1, 0, 3'b010, 2'd0, 13'h0400);
    // self refresh, and refresh with cs high gives plain power-down
    step("R8", 0, 0, 3'b001, 2'd0, 13'h0);
    step("R8", 0, 0, 3'b111, 2'd0, 13'h0);
    step("R8", 1, 0, 3'b111, 2'd0, 13'h0);
    step("R8", 0, 1, 3'b001, 2'd0, 13'h0);
    step("R8", 1, 0, 3'b111, 2'd0, 13'h0);
    nop("R8", 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule